// File: doc/BRIEF.md
# Peripheral Bus Clock-Enable Divider

This block produces a clock-enable strobe for the peripheral bus from the processor clock. The block has no divided clock net. Peripherals stay on the processor clock and advance only in the cycles where the strobe is high. Software picks the ratio through a 2-bit field behind a simple register write and read port.

The codes are not monotonic:

- Code 0 selects one quarter of the processor rate.
- Code 1 selects the full processor rate.
- Code 2 selects one half of the processor rate.
- Code 3 is reserved. A write of code 3 is dropped.

A written code is first held as a request. It is applied only at the end of the current enable period. This means a switch can never produce a short period between two enables.

Top module: `pbus_ce_divider`

## Requirements
- R1: While reset is held and after it is released, the applied code is 0 (quarter rate). The first enable comes in the fourth cycle after the release, counting the first cycle out of reset as cycle one.
- R2: With code 0 (binary 00) applied, `bus_ce` is high in exactly one of every four consecutive processor cycles.
- R3: With code 1 (binary 01) applied, `bus_ce` is high in every processor cycle.
- R4: With code 2 (binary 10) applied, `bus_ce` is high in every other processor cycle.
- R5: A write whose bits 1:0 are 3 (binary 11) changes nothing. A request that is already pending stays pending, and both the read-back value and the enable pattern continue as before.
- R6: A written code takes effect only at the end of an enable period. The cycle with `bus_ce` high is the last cycle of the old period, and the new period starts in the next cycle. Until then, the read-back value and the enable spacing follow the old code.
- R7: `rd_data` returns the applied code in bits 1:0. All higher bits read as 0.
- R8: Write-data bits above bit 1 are ignored. Only bits 1:0 select the ratio.
- R9: Whenever the applied code is not full rate, `bus_ce` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the ratio field |
| wr_data | input | DATA_W | Write data; bits 1:0 carry the ratio code |
| rd_data | output | DATA_W | Read-back of the applied code, zero-extended |
| bus_ce | output | 1 | Single-cycle peripheral enable strobe |

## Verification
The bench builds the block with a 16-bit register port instead of the 32-bit default. At that width the ignored upper write bits and the zero upper read bits are few enough to drive fully. A behavioural model tracks the pending request, the applied code and the position within the period. The model is compared with `bus_ce` and `rd_data` on every cycle. The stimulus includes writes that land in the same cycle as a period end, writes in the middle of a period, reserved writes on top of a pending request, and a switch into and out of full rate.

// File: rtl/pbus_ce_pkg.sv
// Package: shared types and sizing for the peripheral bus clock-enable divider.
// Assumes: the ratio field is two bits wide and the longest period is four cycles.
package pbus_ce_pkg;

    localparam int CODE_W  = 2;
    localparam int MAX_DIV = 4;
    localparam int CNT_W   = $clog2(MAX_DIV);

    // Ratio codes; the order is the software-visible encoding.
    typedef enum logic [CODE_W-1:0] {
        RATE_QUARTER = 2'b00,
        RATE_FULL    = 2'b01,
        RATE_HALF    = 2'b10,
        RATE_RSVD    = 2'b11
    } rate_code_e;

    // Last counter value of one enable period for a given code.
    function automatic logic [CNT_W-1:0] period_last(input rate_code_e code);
        case (code)
            RATE_FULL: period_last = CNT_W'(0);
            RATE_HALF: period_last = CNT_W'(1);
            default:   period_last = CNT_W'(MAX_DIV - 1);
        endcase
    endfunction

endpackage

// File: rtl/pbus_ce_req_reg.sv
// Module: holds the ratio code that software requested.
// Assumes: only bits 1:0 of the write data matter; the reserved code is dropped.
module pbus_ce_req_reg
    import pbus_ce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output rate_code_e        req_code
);

    rate_code_e wr_code;
    rate_code_e req_q;

    assign wr_code  = rate_code_e'(wr_data[CODE_W-1:0]);
    assign req_code = req_q;

    // Capture a write unless it carries the reserved code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= RATE_QUARTER;
        end else if (wr_en && (wr_code != RATE_RSVD)) begin
            req_q <= wr_code;
        end
    end

    assert_reserved_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CODE_W-1:0] == 2'b11) |=> $stable(req_q));

    assert_upper_bits_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[DATA_W-1:CODE_W] != '0) && (wr_data[CODE_W-1:0] != 2'b11))
        |=> (req_q == $past(wr_data[CODE_W-1:0])));

endmodule

// File: rtl/pbus_ce_counter.sv
// Module: counts processor cycles within one enable period and raises the strobe on the last one.
// Assumes: the requested code is never the reserved value; it is loaded only when the period wraps.
module pbus_ce_counter
    import pbus_ce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rate_code_e req_code,
    output rate_code_e applied_code,
    output logic       ce
);

    logic [CNT_W-1:0] cnt_q;
    rate_code_e       applied_q;
    logic             wrap;

    // The last cycle of a period is both the strobe cycle and the reload point.
    assign wrap         = (cnt_q == period_last(applied_q));
    assign ce           = wrap;
    assign applied_code = applied_q;

    // Advance the counter; at the wrap, restart it and take in the pending code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            applied_q <= RATE_QUARTER;
        end else if (wrap) begin
            cnt_q     <= '0;
            applied_q <= req_code;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_hold_between_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(applied_q));

    assert_full_rate_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (applied_q == RATE_FULL) |-> ce);

    assert_single_cycle_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && applied_q != RATE_FULL) |=> (!ce || applied_q == RATE_FULL));

    assert_no_reserved_applied_R5: assert property (@(posedge clk) disable iff (!rst_n)
        applied_q != RATE_RSVD);

endmodule

// File: rtl/pbus_ce_divider.sv
// Module: top of the peripheral bus clock-enable divider.
// Assumes: DATA_W is at least 3; the read port is combinational from the applied code.
module pbus_ce_divider
    import pbus_ce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_ce
);

    rate_code_e req_code;
    rate_code_e applied_code;

    pbus_ce_req_reg #(.DATA_W(DATA_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .req_code (req_code)
    );

    pbus_ce_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_code     (req_code),
        .applied_code (applied_code),
        .ce           (bus_ce)
    );

    // Read-back: the applied code, zero-extended.
    assign rd_data = DATA_W'(applied_code);

    assert_readback_follows_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ce |=> $stable(rd_data));

endmodule

// File: tb/pbus_ce_divider_tb.sv
module pbus_ce_divider_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          bus_ce;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    // Reference model state
    int m_req = 0;
    int m_app = 0;
    int m_pos = 0;
    bit prev_ce = 1'b0;

    pbus_ce_divider #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bus_ce(bus_ce)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(input int code);
        case (code)
            1: return 1;
            2: return 2;
            default: return 4;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_req = 0; m_app = 0; m_pos = 0;
        end else begin
            if (m_pos == period_of(m_app) - 1) begin
                m_pos = 0;
                m_app = m_req;
            end else begin
                m_pos = m_pos + 1;
            end
            if (wr_en && wr_data[1:0] != 2'b11) m_req = int'(wr_data[1:0]);
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            bit exp_ce;
            exp_ce = (m_pos == period_of(m_app) - 1);
            case (m_app)
                1: check(bus_ce == exp_ce, "R3", int'(bus_ce), int'(exp_ce));
                2: check(bus_ce == exp_ce, "R4", int'(bus_ce), int'(exp_ce));
                default: check(bus_ce == exp_ce, "R2", int'(bus_ce), int'(exp_ce));
            endcase
            check(rd_data == DW'(m_app), "R7", int'(rd_data), m_app);
            if (m_app != 1 && rst_n)
                check(!(prev_ce && bus_ce), "R9", int'(bus_ce), 0);
            prev_ce = bus_ce;
        end
    end

    task automatic do_write(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_ce();
        do @(negedge clk); while (!bus_ce);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rd_data == '0, "R1", int'(rd_data), 0);
        check(bus_ce == 1'b0, "R1", int'(bus_ce), 0);
        rst_n = 1'b1;
        // First enable in the third sample after release (cycle four counting release cycle).
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            check(bus_ce == (i == 3), "R1", int'(bus_ce), int'(i == 3));
        end
        repeat (8) @(negedge clk);

        // Mid-period write of half rate: read-back unchanged until the wrap.
        wait_ce();
        @(negedge clk);
        do_write(DW'(2));
        check(rd_data == '0, "R6", int'(rd_data), 0);
        wait_ce();
        @(negedge clk);
        check(rd_data == DW'(2), "R6", int'(rd_data), 2);
        repeat (10) @(negedge clk);

        // Reserved code over a pending request keeps the request.
        do_write(DW'(1));
        do_write(DW'(3));
        repeat (6) @(negedge clk);
        check(rd_data == DW'(1), "R5", int'(rd_data), 1);
        do_write(DW'(3));
        repeat (4) @(negedge clk);
        check(rd_data == DW'(1) && bus_ce, "R5", int'(rd_data), 1);

        // Upper write bits set: only bits 1:0 count.
        do_write({{(DW-2){1'b1}}, 2'b00});
        repeat (6) @(negedge clk);
        check(rd_data == '0, "R8", int'(rd_data), 0);

        // Writes landing on the wrap cycle.
        wait_ce();
        do_write(DW'(2));
        repeat (12) @(negedge clk);
        wait_ce();
        do_write(DW'(1));
        repeat (5) @(negedge clk);
        do_write(DW'(0));
        repeat (20) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

endmodule